// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Port (Master)

This block is a master-only synchronous serial port. It moves words between a small transmit queue, a serial line and a small receive queue. Software pushes right-aligned words into the transmit queue. The shifter aligns each word on its most significant used bit, clocks it out most significant bit first and collects the incoming bits. It then pushes a right-justified, zero-filled word into the receive queue. Three framings are selectable while the port is idle: a select-style frame with an active-low select held for the whole word, a pulse-style frame that raises the frame line for one serial clock before the data, and a half-duplex command/response framing. The command/response framing sends a fixed 8-bit command, waits one turnaround clock and then reads a response whose length is programmable.

The serial clock is derived from the block clock, which acts as the internal reference, through an 8-bit divider. It can instead follow an external clock input, in which case the serial clock toggles on every rising edge of that input. A single enable input gates all activity. Dropping the enable aborts any word in flight, returns the pins to idle and empties both queues.

Top module: `sync_serial_port`

## Requirements
- R1: The size field `cfg_size_i` encodes word length minus one (values 3..15 give 4..16 bits). In select-style framing a word produces exactly size+1 serial clocks, and `ser_txd_o` carries bits size..0 of the pushed word, most significant first. Bits above that are ignored.
- R2: Each received word enters the receive queue right-justified. The first sampled bit becomes bit `size`, and all bits above `size` are zero.
- R3: Size codes 0, 1 and 2 never start a transfer. A queued word stays queued and is sent once a legal size is programmed.
- R4: Format code 00 (select-style): `ser_frame_o` idles high and is low at every rising serial clock edge of the word. `ser_sclk_o` idles low, data changes after the falling edge and `ser_rxd_i` is sampled on the rising edge.
- R5: Format code 01 (pulse-style): `ser_frame_o` idles low and is high for exactly the first serial clock period. Size+1 data clocks follow with the frame low, for size+2 clocks in total.
- R6: Format code 10 (command/response): bits 7..0 of the pushed word go out first as an 8-bit command. One turnaround clock follows, then size+1 response bits are sampled. The frame is low throughout, for size+10 clocks in total.
- R7: Format code 11 never starts a transfer.
- R8: With `cfg_ext_sel_i`=0 the serial clock period is 2×(`cfg_div_i`+1) block clock cycles.
- R9: With `cfg_ext_sel_i`=1 the serial clock toggles once per rising edge of `ext_clk_i`, so its period is two external clock periods.
- R10: While `cfg_en_i`=0 pushes are ignored, both queues read as empty, and `ser_sclk_o` and `ser_txd_o` are low. Clearing the enable in the middle of a word aborts it and discards every queued word.
- R11: The transmit queue holds FIFO_DEPTH words and raises `tx_full_o` when that many are queued. The receive queue head is visible on `rx_data_o` whenever `rx_empty_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal serial reference |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en_i | input | 1 | Port enable; 0 aborts and flushes |
| cfg_fmt_i | input | 2 | Framing select (00 select, 01 pulse, 10 command/response, 11 none) |
| cfg_size_i | input | 4 | Word length minus one |
| cfg_ext_sel_i | input | 1 | 0 internal divider, 1 external clock |
| cfg_div_i | input | DIV_W | Internal rate divider |
| ext_clk_i | input | 1 | External serial reference clock |
| tx_push_i | input | 1 | Push `tx_data_i` into the transmit queue |
| tx_data_i | input | 16 | Right-aligned transmit word |
| tx_full_o | output | 1 | Transmit queue full |
| rx_pop_i | input | 1 | Remove the receive queue head |
| rx_data_o | output | 16 | Receive queue head |
| rx_empty_o | output | 1 | Receive queue empty |
| ser_sclk_o | output | 1 | Serial clock |
| ser_frame_o | output | 1 | Frame / select line |
| ser_txd_o | output | 1 | Serial transmit data |
| ser_rxd_i | input | 1 | Serial receive data |

## Verification
A bench-side slave model counts serial clocks, captures transmitted bits and feeds a known response. The bench targets the shortest legal word, the full 16-bit word and sizes in between. An error in the alignment shift would send high-order garbage or the wrong bits. A wrong receive fill would leave junk above the word. In command/response framing, a design that forgot the turnaround clock or sized the command by the size field would give the wrong clock count and a shifted response. Further directed cases check the following: a reserved size holds its word until a legal size arrives, the reserved format stays silent while the queue fills to full, a mid-word disable flushes the queued second word, and the divider and external clock give the expected period, where an off-by-one divider shows up as a wrong count.

// File: rtl/ssp_pkg.sv
// Shared constants and the framing enumeration for the synchronous serial port.
// Assumes words never exceed 16 bits and the command word is fixed at 8 bits.
package ssp_pkg;
    localparam int WORD_W   = 16;
    localparam int SIZE_W   = 4;
    localparam int CMD_W    = 8;
    localparam int SLOT_W   = 5;     // holds CMD_W + 1 + WORD_W slots
    localparam int MIN_SIZE = 3;     // smallest legal size code (4 bits)

    typedef enum logic [1:0] {
        FMT_SEL  = 2'b00,
        FMT_PULS = 2'b01,
        FMT_CMDR = 2'b10,
        FMT_NONE = 2'b11
    } fmt_e;
endpackage

// File: rtl/ssp_fifo.sv
// Show-ahead synchronous FIFO with a flush input that takes priority.
// Assumes DEPTH is a power of two, at least 2.
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp_q, rp_q;
    logic         do_push, do_pop;

    assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign empty   = (wp_q == rp_q);
    assign rdata   = mem[rp_q[AW-1:0]];
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    // Pointer update; flush returns both pointers to the same place.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q[AW-1:0]] <= wdata;
    end
endmodule

// File: rtl/ssp_clkgen.sv
// Produces one-cycle half-period ticks for the serial clock, from an
// internal divider or from rising edges of an external clock.
// Assumes the external clock is slower than half the block clock.
module ssp_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_sel,
    input  logic             ext_clk,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [2:0]       ext_sync_q;
    logic             ext_rise;
    logic             div_hit;

    assign ext_rise = ext_sync_q[1] && !ext_sync_q[2];
    assign div_hit  = (cnt_q >= div);
    assign tick     = run && (ext_sel ? ext_rise : div_hit);

    // Bring the external clock into the block domain.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync_q <= '0;
        else        ext_sync_q <= {ext_sync_q[1:0], ext_clk};
    end

    // Divider counter, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || ext_sel) cnt_q <= '0;
        else if (div_hit)              cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ssp_engine.sv
// Frame engine: one shifter serving three framings. A frame is a run of
// slots, each one serial clock long (low half then high half). Transmit data
// changes on the falling edge; receive data is sampled on the rising edge.
// Assumes configuration changes only while no word is in flight.
module ssp_engine
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  fmt_e              cfg_fmt,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    input  logic              rx_ready,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    input  logic              rxd,
    output logic              sclk,
    output logic              frame,
    output logic              txd,
    output logic              busy,
    output fmt_e              act_fmt
);
    fmt_e              fmt_q;
    logic [SIZE_W-1:0] size_q;
    logic              busy_q, half_q;
    logic [SLOT_W-1:0] slot_q, len, last_slot;
    logic [WORD_W-1:0] tx_sr_q, rx_sr_q, tx_load;
    logic              tx_slot, rx_slot, start, slot_end;

    assign len = SLOT_W'(size_q) + SLOT_W'(1);

    // Slot roles and frame length for the latched framing.
    always_comb begin
        case (fmt_q)
            FMT_PULS: begin
                tx_slot   = (slot_q != '0);
                rx_slot   = (slot_q != '0);
                last_slot = len;
            end
            FMT_CMDR: begin
                tx_slot   = (slot_q < SLOT_W'(CMD_W));
                rx_slot   = (slot_q > SLOT_W'(CMD_W));
                last_slot = len + SLOT_W'(CMD_W);
            end
            default: begin
                tx_slot   = 1'b1;
                rx_slot   = 1'b1;
                last_slot = len - SLOT_W'(1);
            end
        endcase
    end

    // Left-justify the outgoing word for the chosen framing.
    always_comb begin
        if (cfg_fmt == FMT_CMDR)
            tx_load = {tx_word[CMD_W-1:0], {(WORD_W-CMD_W){1'b0}}};
        else
            tx_load = tx_word << (SIZE_W'(WORD_W-1) - cfg_size);
    end

    assign start    = en && tick && !busy_q && tx_valid && rx_ready
                      && (cfg_fmt != FMT_NONE) && (cfg_size >= SIZE_W'(MIN_SIZE));
    assign slot_end = en && tick && busy_q && half_q;
    assign tx_pop   = start;
    assign rx_push  = slot_end && (slot_q == last_slot);
    assign rx_word  = rx_sr_q;

    // Frame sequencing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy_q  <= 1'b0;
            half_q  <= 1'b0;
            slot_q  <= '0;
            fmt_q   <= FMT_SEL;
            size_q  <= '0;
            tx_sr_q <= '0;
            rx_sr_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            half_q  <= 1'b0;
            slot_q  <= '0;
            fmt_q   <= cfg_fmt;
            size_q  <= cfg_size;
            tx_sr_q <= tx_load;
            rx_sr_q <= '0;
        end else if (tick && busy_q) begin
            half_q <= !half_q;
            if (!half_q) begin
                if (rx_slot) rx_sr_q <= {rx_sr_q[WORD_W-2:0], rxd};
            end else begin
                if (tx_slot) tx_sr_q <= tx_sr_q << 1;
                if (slot_q == last_slot) busy_q <= 1'b0;
                else                     slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign sclk    = busy_q && half_q;
    assign txd     = busy_q && tx_slot && tx_sr_q[WORD_W-1];
    assign busy    = busy_q;
    assign act_fmt = fmt_q;

    // Frame line: idle level depends on the selected framing.
    always_comb begin
        if (busy_q) frame = (fmt_q == FMT_PULS) ? (slot_q == '0) : 1'b0;
        else        frame = (cfg_fmt != FMT_PULS);
    end
endmodule

// File: rtl/sync_serial_port.sv
// Top level: transmit queue, receive queue, rate generator and frame engine.
// Assumes ser_rxd_i is already synchronous to clk.
module sync_serial_port #(
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en_i,
    input  logic [1:0]       cfg_fmt_i,
    input  logic [3:0]       cfg_size_i,
    input  logic             cfg_ext_sel_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic             ext_clk_i,
    input  logic             tx_push_i,
    input  logic [15:0]      tx_data_i,
    output logic             tx_full_o,
    input  logic             rx_pop_i,
    output logic [15:0]      rx_data_o,
    output logic             rx_empty_o,
    output logic             ser_sclk_o,
    output logic             ser_frame_o,
    output logic             ser_txd_o,
    input  logic             ser_rxd_i
);
    import ssp_pkg::*;

    logic              tick, tx_empty, tx_pop, rx_full, rx_push, busy;
    logic [WORD_W-1:0] tx_head, rx_word;
    fmt_e              act_fmt;
    logic [1:0]        act_fmt_bits;

    assign act_fmt_bits = act_fmt;

    ssp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(!cfg_en_i),
        .push(tx_push_i), .wdata(tx_data_i), .full(tx_full_o),
        .pop(tx_pop), .rdata(tx_head), .empty(tx_empty)
    );

    ssp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!cfg_en_i),
        .push(rx_push), .wdata(rx_word), .full(rx_full),
        .pop(rx_pop_i), .rdata(rx_data_o), .empty(rx_empty_o)
    );

    ssp_clkgen #(.DIV_W(DIV_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(cfg_en_i), .ext_sel(cfg_ext_sel_i),
        .ext_clk(ext_clk_i), .div(cfg_div_i), .tick(tick)
    );

    ssp_engine u_eng (
        .clk(clk), .rst_n(rst_n), .en(cfg_en_i), .tick(tick),
        .cfg_fmt(fmt_e'(cfg_fmt_i)), .cfg_size(cfg_size_i),
        .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_ready(!rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .rxd(ser_rxd_i), .sclk(ser_sclk_o), .frame(ser_frame_o),
        .txd(ser_txd_o), .busy(busy), .act_fmt(act_fmt)
    );
endmodule

// File: rtl/ssp_checker.sv
// Protocol checks on the serial port, attached to the top with bind.
module ssp_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic [1:0]       cfg_fmt,
    input logic [3:0]       cfg_size,
    input logic             cfg_ext_sel,
    input logic [DIV_W-1:0] cfg_div,
    input logic             sclk,
    input logic             frame,
    input logic             txd,
    input logic             rx_empty,
    input logic             tx_full,
    input logic             busy,
    input logic [1:0]       act_fmt
);
    // R10
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!sclk && !txd && rx_empty && !tx_full));

    // R7
    no_fmt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_fmt == 2'b11) |=> !busy);

    // R3
    no_size_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_size < 4'd3) |=> !busy);

    // R4
    select_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && act_fmt != 2'b01) |-> !frame);

    // R8
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ext_sel && cfg_div != '0 && !$stable(sclk))
            |=> ($stable(sclk) || !$past(cfg_en)));
endmodule

bind sync_serial_port ssp_checker #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en_i), .cfg_fmt(cfg_fmt_i),
    .cfg_size(cfg_size_i), .cfg_ext_sel(cfg_ext_sel_i), .cfg_div(cfg_div_i),
    .sclk(ser_sclk_o), .frame(ser_frame_o), .txd(ser_txd_o),
    .rx_empty(rx_empty_o), .tx_full(tx_full_o), .busy(busy),
    .act_fmt(act_fmt_bits)
);

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
    localparam int DEPTH = 4;

    logic        clk = 0, rst_n = 0;
    logic        en = 0, ext_sel = 0, ext_clk = 0;
    logic [1:0]  fmt = 0;
    logic [3:0]  size = 7;
    logic [7:0]  div = 0;
    logic        tx_push = 0, rx_pop = 0, rxd = 0;
    logic [15:0] tx_data = 0;
    logic        tx_full, rx_empty, sclk, frame, txd;
    logic [15:0] rx_data;

    int n_chk = 0, n_err = 0;

    // slave model state
    int          rise_cnt = 0, frl = 0, frh = 0, per = 0, last_rise = 0, cyc = 0;
    logic [31:0] cap = 0;
    logic        sclk_prev = 0;
    logic [1:0]  m_fmt = 0;
    int          m_n = 8;
    logic [15:0] m_resp = 0;

    // fmt, size, div, word, resp
    localparam logic [45:0] VEC [8] = '{
        {2'b00, 4'd7,  8'd1, 16'h00A5, 16'h003C},
        {2'b00, 4'd15, 8'd0, 16'hBEEF, 16'h1234},
        {2'b00, 4'd3,  8'd2, 16'hFFF9, 16'hFFF6},
        {2'b01, 4'd11, 8'd0, 16'h0ABC, 16'h0F0F},
        {2'b01, 4'd3,  8'd3, 16'h0005, 16'h000A},
        {2'b10, 4'd7,  8'd0, 16'h12C3, 16'h005A},
        {2'b10, 4'd15, 8'd1, 16'h0081, 16'hC001},
        {2'b00, 4'd9,  8'd7, 16'h02AA, 16'h0155}
    };

    sync_serial_port #(.FIFO_DEPTH(DEPTH), .DIV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en_i(en), .cfg_fmt_i(fmt),
        .cfg_size_i(size), .cfg_ext_sel_i(ext_sel), .cfg_div_i(div),
        .ext_clk_i(ext_clk), .tx_push_i(tx_push), .tx_data_i(tx_data),
        .tx_full_o(tx_full), .rx_pop_i(rx_pop), .rx_data_o(rx_data),
        .rx_empty_o(rx_empty), .ser_sclk_o(sclk), .ser_frame_o(frame),
        .ser_txd_o(txd), .ser_rxd_i(rxd)
    );

    always #2.5 clk = ~clk;
    initial forever #25 ext_clk = ~ext_clk;

    function automatic logic slave_bit(int k);
        int idx;
        idx = (m_fmt == 2'b01) ? k - 1 : (m_fmt == 2'b10) ? k - 9 : k;
        if (idx >= 0 && idx < m_n) return m_resp[m_n-1-idx];
        return 1'b0;
    endfunction

    // Slave model: observe serial pins away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (sclk && !sclk_prev) begin
            cap = {cap[30:0], txd};
            if (frame) frh++; else frl++;
            if (rise_cnt > 0) per = cyc - last_rise;
            last_rise = cyc;
            rise_cnt++;
        end
        sclk_prev = sclk;
        rxd = slave_bit(rise_cnt);
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset(logic [1:0] f, int n, logic [15:0] r);
        m_fmt = f; m_n = n; m_resp = r;
        rise_cnt = 0; frl = 0; frh = 0; per = 0; cap = 0;
    endtask

    task automatic push_word(logic [15:0] w);
        tx_push = 1; tx_data = w;
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic wait_rx();
        for (int k = 0; k < 4000 && rx_empty; k++) @(negedge clk);
    endtask

    task automatic pop_word();
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic run_vec(logic [45:0] v);
        logic [1:0]  f;
        logic [15:0] w, r, mask;
        int n, exp_r, exp_frl, exp_frh;
        string rq;
        f = v[45:44]; n = int'(v[43:40]) + 1; w = v[31:16]; r = v[15:0];
        mask = 16'((32'd1 << n) - 1);
        @(negedge clk);
        fmt = f; size = v[43:40]; div = v[39:32];
        model_reset(f, n, r);
        push_word(w);
        wait_rx();
        rq      = (f == 2'b01) ? "R5" : (f == 2'b10) ? "R6" : "R1";
        exp_r   = (f == 2'b01) ? n + 1 : (f == 2'b10) ? n + 9 : n;
        exp_frh = (f == 2'b01) ? 1 : 0;
        exp_frl = exp_r - exp_frh;
        check(rise_cnt == exp_r, rq, "clock count", rise_cnt, exp_r);
        if (f == 2'b10)
            check(((cap >> (n + 1)) & 32'hFF) == {24'h0, w[7:0]}, rq, "command bits",
                  int'((cap >> (n + 1)) & 32'hFF), int'(w[7:0]));
        else
            check((cap[15:0] & mask) == (w & mask), rq, "tx bits",
                  int'(cap[15:0] & mask), int'(w & mask));
        check(rx_data == (r & mask), "R2", "rx word", rx_data, r & mask);
        check(frh == exp_frh && frl == exp_frl, (f == 2'b00) ? "R4" : rq, "frame level at rises",
              frh * 256 + frl, exp_frh * 256 + exp_frl);
        check(per == 2 * (int'(v[39:32]) + 1), "R8", "sclk period", per, 2 * (int'(v[39:32]) + 1));
        pop_word();
    endtask

    initial begin
        #(5ns * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state, enable low
        check(!sclk && frame && !txd, "R10", "idle pins after reset", {sclk, frame, txd}, 3'b010);
        check(rx_empty && !tx_full, "R10", "queues after reset", {rx_empty, tx_full}, 2'b10);

        // pushes ignored while disabled
        push_word(16'h00FF);
        check(!tx_full && rx_empty, "R10", "flags after disabled push", {tx_full, rx_empty}, 2'b01);
        en = 1;
        model_reset(2'b00, 8, 16'h0);
        repeat (200) @(negedge clk);
        check(rise_cnt == 0, "R10", "clocks after disabled push", rise_cnt, 0);

        // vector table
        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // reserved size holds the word until legal
        fmt = 2'b00; size = 4'd2; div = 0;
        model_reset(2'b00, 8, 16'h0081);
        push_word(16'h00C6);
        repeat (300) @(negedge clk);
        check(rise_cnt == 0 && rx_empty, "R3", "clocks with reserved size", rise_cnt, 0);
        size = 4'd7;
        wait_rx();
        check(rise_cnt == 8 && cap[7:0] == 8'hC6, "R3", "held word sent", int'(cap[7:0]), 8'hC6);
        check(rx_data == 16'h0081, "R2", "rx after held word", rx_data, 16'h0081);
        pop_word();

        // reserved format: silent, queue fills
        fmt = 2'b11;
        model_reset(2'b00, 8, 16'h0);
        for (int i = 0; i < DEPTH; i++) push_word(16'(i + 1));
        repeat (200) @(negedge clk);
        check(rise_cnt == 0, "R7", "clocks with reserved format", rise_cnt, 0);
        check(tx_full, "R11", "full after DEPTH pushes", tx_full, 1);
        en = 0;
        @(negedge clk);
        check(!tx_full && rx_empty, "R10", "flush on disable", {tx_full, rx_empty}, 2'b01);
        en = 1;

        // abort mid-word, second word discarded
        fmt = 2'b00; size = 4'd15; div = 8'd7;
        model_reset(2'b00, 16, 16'hFFFF);
        push_word(16'hAAAA);
        push_word(16'h5555);
        for (int k = 0; k < 2000 && rise_cnt < 3; k++) @(negedge clk);
        en = 0;
        @(negedge clk);
        check(!sclk && frame && !txd, "R10", "pins idle after abort", {sclk, frame, txd}, 3'b010);
        check(rx_empty && !tx_full, "R10", "queues after abort", {rx_empty, tx_full}, 2'b10);
        en = 1;
        repeat (400) @(negedge clk);
        check(rise_cnt == 3 && rx_empty, "R10", "no transfer after abort", rise_cnt, 3);

        // external clock
        ext_sel = 1; size = 4'd7;
        model_reset(2'b00, 8, 16'h0069);
        push_word(16'h0096);
        wait_rx();
        check(per == 20, "R9", "external sclk period", per, 20);
        check(cap[7:0] == 8'h96 && rx_data == 16'h0069, "R9", "external transfer data",
              rx_data, 16'h0069);
        check(!rx_empty, "R11", "rx head visible", rx_empty, 0);
        pop_word();
        check(rx_empty, "R11", "rx empty after pop", rx_empty, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule